// File: doc/BRIEF.md
# Flash erase command sequencer

This block sits on the host side of a parallel NOR-style flash bus and starts either a block erase or a sector erase. A one-clock start pulse launches an erase. With it come an erase-type select, a strobe-mode select, the write-protect level to present and the target address. The sequencer first drives the write-protect pin to the requested level and waits out a setup margin of at least one microsecond. It then issues the six-write erase sequence on the address and data pins. Last, it waits out the same margin as a hold time and reports completion with a single-clock done pulse.

Each bus write is strobed on either the write-enable or the chip-enable pin. The other one of the two is held low for the whole write. The output-enable pin is never asserted. The address width is 20 or 21 bits, picked by a density parameter. The microsecond margins are derived from a clock-frequency parameter, and the strobe width is a parameter as well. Polling for the end of the internal erase is left to other logic.

Top module: `flash_erase_seq`

## Requirements
- R1: An accepted start produces exactly six bus writes, in the order (addr 0x5555, data 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), followed by the erase command write. Addresses are zero-extended to the bus width.
- R2: With `sector_sel_i` = 0 (block erase), the sixth write puts 0x50 on the low data byte at `target_addr_i`.
- R3: With `sector_sel_i` = 1 (sector erase), the sixth write puts 0x30 on the low data byte at `target_addr_i`.
- R4: Bits 15:8 of `flash_dq_o` are 0x00 on every write.
- R5: The address bus is 21 bits wide when `DENSITY_LARGE` = 1 and 20 bits wide otherwise. Every target bit, including the top one, appears on the sixth write.
- R6: `wp_n_o` takes the value of `wp_level_i` on the clock edge that accepts a start, and stays constant while busy. The first strobe falls exactly US+1 clocks after that edge, where US = ceil(`CLK_HZ` / 1e6).
- R7: `done_o` rises exactly US+1 clocks after the last strobe rises. The clock following the rise is the address hold cycle, and US clocks of write-protect hold come after it.
- R8: With `ce_strobe_i` = 0, `flash_we_n_o` pulses and `flash_ce_n_o` is low for the whole write, including the setup and hold clocks. With `ce_strobe_i` = 1 the two pins swap roles. Both pins are high while idle. Both mode selects are sampled at the accepted start.
- R9: `flash_oe_n_o` stays high at all times, including the whole sequence.
- R10: Each strobe is low for exactly `STROBE_CYC` clocks. Address and data are driven one clock before the strobe falls, stay stable while it is low, and are held for the clock in which it rises.
- R11: A start pulse that arrives while busy is ignored. The sequence in progress continues unchanged, and no new sequence follows it.
- R12: `busy_o` is high from the clock after the accepted start until `done_o` rises. `done_o` is high for one clock, with `busy_o` low in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin an erase |
| sector_sel_i | input | 1 | 0 = block erase, 1 = sector erase |
| ce_strobe_i | input | 1 | 0 = strobe on write-enable, 1 = strobe on chip-enable |
| wp_level_i | input | 1 | Level to drive on the write-protect pin for this erase |
| target_addr_i | input | ADDR_W | Block or sector address for the final write |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_dq_o | output | 16 | Flash data bus (write direction) |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low (held high) |
| wp_n_o | output | 1 | Write-protect pin level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench targets the margins where an off-by-one is easy. It checks the exact clock of the first strobe fall after start and the exact clock of done after the last strobe rise. A design that shortens the setup or hold count by one would fail these checks, and so would one that skips the address setup or hold clock. The bench also checks the strobe width and the hold cycle. A missing hold clock would show up as a changed address on the rising edge, and a miscounted timer would give the wrong pulse width. Both strobe modes are run, and the unused strobe is checked to stay low through each write. Swapping the pins or releasing the unused strobe early would be caught there. A start pulse injected mid-sequence with the opposite erase type shows whether the design restarts, shortens the sequence or changes its final opcode. A target address with the top bit set exposes an address path truncated to the smaller density.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WP_SETUP,
      PH_ADDR_SU,
      PH_STROBE,
      PH_ADDR_HOLD,
      PH_WP_HOLD
   } phase_t;

   localparam int unsigned NUM_WRITES = 6;
   localparam int unsigned STEP_W     = $clog2(NUM_WRITES);

   localparam logic [15:0] UNLOCK_ADR_HI = 16'h5555;
   localparam logic [15:0] UNLOCK_ADR_LO = 16'h2AAA;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] KEY_ARM    = 8'h80;
   localparam logic [7:0] OP_BLOCK   = 8'h50;
   localparam logic [7:0] OP_SECTOR  = 8'h30;

endpackage

// File: rtl/flash_erase_cmd_table.sv
module flash_erase_cmd_table
   import flash_erase_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic              sector_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [15:0]       data_o
);

   localparam logic [ADDR_W-1:0] ADR_HI = ADDR_W'(UNLOCK_ADR_HI);
   localparam logic [ADDR_W-1:0] ADR_LO = ADDR_W'(UNLOCK_ADR_LO);

   logic [7:0] final_op;
   logic [7:0] cmd_byte;

   always_comb begin
      final_op = sector_i ? OP_SECTOR : OP_BLOCK;
   end

   always_comb begin
      unique case (step_i)
         3'd0:    begin addr_o = ADR_HI;   cmd_byte = KEY_FIRST;  end
         3'd1:    begin addr_o = ADR_LO;   cmd_byte = KEY_SECOND; end
         3'd2:    begin addr_o = ADR_HI;   cmd_byte = KEY_ARM;    end
         3'd3:    begin addr_o = ADR_HI;   cmd_byte = KEY_FIRST;  end
         3'd4:    begin addr_o = ADR_LO;   cmd_byte = KEY_SECOND; end
         default: begin addr_o = target_i; cmd_byte = final_op;   end
      endcase
   end

   // The command rides on the low byte; the upper byte is driven to zero.
   always_comb begin
      data_o = {8'h00, cmd_byte};
   end

endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      expired_o = (cnt_q == '0);
   end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
   import flash_erase_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned MARGIN_CYC = 100,
   parameter int unsigned STROBE_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sector_sel_i,
   input  logic              ce_strobe_i,
   input  logic              wp_level_i,
   input  logic [ADDR_W-1:0] target_addr_i,
   input  logic              tmr_expired_i,
   output logic              tmr_load_o,
   output logic [CNT_W-1:0]  tmr_val_o,
   output phase_t            phase_o,
   output logic [STEP_W-1:0] step_o,
   output logic              sector_o,
   output logic              ce_mode_o,
   output logic [ADDR_W-1:0] target_o,
   output logic              wp_o,
   output logic              done_o
);

   localparam logic [CNT_W-1:0]  MARGIN_LOAD = CNT_W'(MARGIN_CYC - 1);
   localparam logic [CNT_W-1:0]  STROBE_LOAD = CNT_W'(STROBE_CYC - 1);
   localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(NUM_WRITES - 1);

   phase_t            phase_q, phase_d;
   logic [STEP_W-1:0] step_q;
   logic              sector_q, ce_mode_q, wp_q, done_q;
   logic [ADDR_W-1:0] target_q;
   logic              accept;

   always_comb begin
      accept = (phase_q == PH_IDLE) && start_i;
   end

   always_comb begin
      phase_d    = phase_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = MARGIN_LOAD;
      unique case (phase_q)
         PH_IDLE: begin
            if (start_i) begin
               phase_d    = PH_WP_SETUP;
               tmr_load_o = 1'b1;
            end
         end
         PH_WP_SETUP: begin
            if (tmr_expired_i) phase_d = PH_ADDR_SU;
         end
         PH_ADDR_SU: begin
            phase_d    = PH_STROBE;
            tmr_load_o = 1'b1;
            tmr_val_o  = STROBE_LOAD;
         end
         PH_STROBE: begin
            if (tmr_expired_i) phase_d = PH_ADDR_HOLD;
         end
         PH_ADDR_HOLD: begin
            if (step_q == LAST_STEP) begin
               phase_d    = PH_WP_HOLD;
               tmr_load_o = 1'b1;
            end else begin
               phase_d = PH_ADDR_SU;
            end
         end
         PH_WP_HOLD: begin
            if (tmr_expired_i) phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         step_q    <= '0;
         sector_q  <= 1'b0;
         ce_mode_q <= 1'b0;
         wp_q      <= 1'b0;
         target_q  <= '0;
         done_q    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_WP_HOLD) && tmr_expired_i;
         if (accept) begin
            step_q    <= '0;
            sector_q  <= sector_sel_i;
            ce_mode_q <= ce_strobe_i;
            wp_q      <= wp_level_i;
            target_q  <= target_addr_i;
         end else if (phase_q == PH_ADDR_HOLD && step_q != LAST_STEP) begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   always_comb begin
      phase_o   = phase_q;
      step_o    = step_q;
      sector_o  = sector_q;
      ce_mode_o = ce_mode_q;
      target_o  = target_q;
      wp_o      = wp_q;
      done_o    = done_q;
   end

endmodule

// File: rtl/flash_erase_pins.sv
module flash_erase_pins
   import flash_erase_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  phase_t            phase_i,
   input  logic              ce_mode_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [15:0]       cmd_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [15:0]       dq_o,
   output logic              we_n_o,
   output logic              ce_n_o,
   output logic              oe_n_o,
   output logic              busy_o
);

   logic in_write;
   logic active_n;
   logic unused_n;

   always_comb begin
      in_write = (phase_i == PH_ADDR_SU) || (phase_i == PH_STROBE) ||
                 (phase_i == PH_ADDR_HOLD);
      active_n = (phase_i != PH_STROBE);
      unused_n = !in_write;
      we_n_o   = ce_mode_i ? unused_n : active_n;
      ce_n_o   = ce_mode_i ? active_n : unused_n;
      oe_n_o   = 1'b1;
      addr_o   = in_write ? cmd_addr_i : '0;
      dq_o     = in_write ? cmd_data_i : 16'h0000;
      busy_o   = (phase_i != PH_IDLE);
   end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import flash_erase_pkg::*;
#(
   parameter bit          DENSITY_LARGE = 1'b0,
   parameter int unsigned CLK_HZ        = 100_000_000,
   parameter int unsigned STROBE_CYC    = 3,
   localparam int unsigned ADDR_W       = DENSITY_LARGE ? 21 : 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sector_sel_i,
   input  logic              ce_strobe_i,
   input  logic              wp_level_i,
   input  logic [ADDR_W-1:0] target_addr_i,
   output logic [ADDR_W-1:0] flash_addr_o,
   output logic [15:0]       flash_dq_o,
   output logic              flash_we_n_o,
   output logic              flash_ce_n_o,
   output logic              flash_oe_n_o,
   output logic              wp_n_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int unsigned MARGIN_CYC = (CLK_HZ + 999_999) / 1_000_000;
   localparam int unsigned MAX_LOAD   = (MARGIN_CYC > STROBE_CYC) ? MARGIN_CYC : STROBE_CYC;
   localparam int unsigned CNT_W      = (MAX_LOAD < 2) ? 1 : $clog2(MAX_LOAD);

   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("STROBE_CYC must be at least 1");
   end
   if (CLK_HZ < 1) begin : g_bad_clk
      $error("CLK_HZ must be at least 1");
   end

   phase_t            phase;
   logic [STEP_W-1:0] step;
   logic              sector_q, ce_mode_q, wp_q;
   logic [ADDR_W-1:0] target_q;
   logic              tmr_load, tmr_expired;
   logic [CNT_W-1:0]  tmr_val;
   logic [ADDR_W-1:0] cmd_addr;
   logic [15:0]       cmd_data;

   flash_erase_ctrl #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .MARGIN_CYC (MARGIN_CYC),
      .STROBE_CYC (STROBE_CYC)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .sector_sel_i  (sector_sel_i),
      .ce_strobe_i   (ce_strobe_i),
      .wp_level_i    (wp_level_i),
      .target_addr_i (target_addr_i),
      .tmr_expired_i (tmr_expired),
      .tmr_load_o    (tmr_load),
      .tmr_val_o     (tmr_val),
      .phase_o       (phase),
      .step_o        (step),
      .sector_o      (sector_q),
      .ce_mode_o     (ce_mode_q),
      .target_o      (target_q),
      .wp_o          (wp_q),
      .done_o        (done_o)
   );

   flash_erase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_expired)
   );

   flash_erase_cmd_table #(
      .ADDR_W (ADDR_W)
   ) u_table (
      .step_i   (step),
      .sector_i (sector_q),
      .target_i (target_q),
      .addr_o   (cmd_addr),
      .data_o   (cmd_data)
   );

   flash_erase_pins #(
      .ADDR_W (ADDR_W)
   ) u_pins (
      .phase_i    (phase),
      .ce_mode_i  (ce_mode_q),
      .cmd_addr_i (cmd_addr),
      .cmd_data_i (cmd_data),
      .addr_o     (flash_addr_o),
      .dq_o       (flash_dq_o),
      .we_n_o     (flash_we_n_o),
      .ce_n_o     (flash_ce_n_o),
      .oe_n_o     (flash_oe_n_o),
      .busy_o     (busy_o)
   );

   always_comb begin
      wp_n_o = wp_q;
   end

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
   parameter int unsigned ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] flash_addr_o,
   input logic [15:0]       flash_dq_o,
   input logic              flash_we_n_o,
   input logic              flash_ce_n_o,
   input logic              flash_oe_n_o,
   input logic              wp_n_o,
   input logic              busy_o,
   input logic              done_o
);

   logic both_low;
   always_comb both_low = !flash_we_n_o && !flash_ce_n_o;

   // R9
   oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> flash_oe_n_o);

   // R8
   idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (flash_we_n_o && flash_ce_n_o));

   // R6
   wp_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(wp_n_o));

   // R10
   strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (both_low && $past(both_low)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));

   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R11
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind flash_erase_seq flash_erase_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .flash_addr_o (flash_addr_o),
   .flash_dq_o   (flash_dq_o),
   .flash_we_n_o (flash_we_n_o),
   .flash_ce_n_o (flash_ce_n_o),
   .flash_oe_n_o (flash_oe_n_o),
   .wp_n_o       (wp_n_o),
   .busy_o       (busy_o),
   .done_o       (done_o)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;

   localparam int AW = 21;
   localparam int US = 100;
   localparam int SC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          sector_sel_i = 1'b0;
   logic          ce_strobe_i = 1'b0;
   logic          wp_level_i = 1'b0;
   logic [AW-1:0] target_addr_i = '0;
   logic [AW-1:0] flash_addr_o;
   logic [15:0]   flash_dq_o;
   logic          flash_we_n_o, flash_ce_n_o, flash_oe_n_o, wp_n_o, busy_o, done_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flash_erase_seq #(
      .DENSITY_LARGE (1'b1),
      .CLK_HZ        (100_000_000),
      .STROBE_CYC    (SC)
   ) dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .sector_sel_i (sector_sel_i), .ce_strobe_i (ce_strobe_i),
      .wp_level_i (wp_level_i), .target_addr_i (target_addr_i),
      .flash_addr_o (flash_addr_o), .flash_dq_o (flash_dq_o),
      .flash_we_n_o (flash_we_n_o), .flash_ce_n_o (flash_ce_n_o),
      .flash_oe_n_o (flash_oe_n_o), .wp_n_o (wp_n_o),
      .busy_o (busy_o), .done_o (done_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr(input int k, input logic [AW-1:0] tgt);
      case (k)
         0, 2, 3: return AW'(16'h5555);
         1, 4:    return AW'(16'h2AAA);
         default: return tgt;
      endcase
   endfunction

   function automatic logic [15:0] exp_data(input int k, input bit sec);
      case (k)
         0, 3:    return 16'h00AA;
         1, 4:    return 16'h0055;
         2:       return 16'h0080;
         default: return sec ? 16'h0030 : 16'h0050;
      endcase
   endfunction

   // Runs one erase and checks every bus cycle. extra > 0 injects a start
   // pulse of the opposite erase type at that sample while busy.
   task automatic run_erase(input bit sec, input bit cem, input bit wpl,
                            input logic [AW-1:0] tgt, input int extra);
      int nw = 0;
      int width = 0;
      int last_rise = -1;
      int done_at = -1;
      bit prev_act = 1'b1;
      bit bad_unused = 1'b0;
      bit bad_oe = 1'b0;
      bit bad_wp = 1'b0;
      bit bad_stable = 1'b0;
      logic [AW-1:0] prev_addr = '0;
      logic [15:0]   prev_data = '0;
      @(negedge clk);
      sector_sel_i = sec; ce_strobe_i = cem; wp_level_i = wpl; target_addr_i = tgt;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wp_level_i = ~wpl;
      sector_sel_i = ~sec;
      ce_strobe_i = ~cem;
      for (int idx = 1; idx < 3000; idx++) begin
         bit act;
         bit un;
         act = cem ? flash_ce_n_o : flash_we_n_o;
         un  = cem ? flash_we_n_o : flash_ce_n_o;
         if (idx == 1) begin
            check(busy_o == 1'b1, "R12 busy after start", busy_o, 1);
            check(wp_n_o == wpl, "R6 wp level", wp_n_o, wpl);
         end
         if (extra > 0 && idx == extra) begin
            start_i = 1'b1;
            target_addr_i = ~tgt;
         end
         if (extra > 0 && idx == extra + 1) start_i = 1'b0;
         if (busy_o && !flash_oe_n_o) bad_oe = 1'b1;
         if (busy_o && wp_n_o != wpl) bad_wp = 1'b1;
         if (act == 1'b0 && un != 1'b0) bad_unused = 1'b1;
         if (prev_act && !act) begin
            check(flash_addr_o == prev_addr && flash_dq_o == prev_data,
                  "R10 address/data setup", flash_addr_o, prev_addr);
            if (nw < 6) begin
               check(flash_addr_o == exp_addr(nw, tgt),
                     (nw == 5) ? "R5 final write address" : "R1 write address",
                     flash_addr_o, exp_addr(nw, tgt));
               check(flash_dq_o == exp_data(nw, sec),
                     (nw == 5) ? (sec ? "R3 sector opcode" : "R2 block opcode") : "R1 write data",
                     flash_dq_o, exp_data(nw, sec));
               check(flash_dq_o[15:8] == 8'h00, "R4 upper byte", flash_dq_o[15:8], 0);
            end
            if (nw == 0) check(idx == US + 2, "R6 setup margin", idx, US + 2);
            nw++;
            width = 1;
         end else if (!act) begin
            width++;
            if (flash_addr_o != prev_addr || flash_dq_o != prev_data) bad_stable = 1'b1;
         end
         if (!prev_act && act) begin
            check(width == SC, "R10 strobe width", width, SC);
            check(flash_addr_o == prev_addr && flash_dq_o == prev_data,
                  "R10 address/data hold", flash_addr_o, prev_addr);
            check(un == 1'b0, "R8 unused strobe in hold", un, 0);
            last_rise = idx;
         end
         if (done_o) begin
            done_at = idx;
            break;
         end
         prev_act  = act;
         prev_addr = flash_addr_o;
         prev_data = flash_dq_o;
         @(negedge clk);
      end
      check(done_at == last_rise + US + 1, "R7 hold margin", done_at, last_rise + US + 1);
      check(busy_o == 1'b0, "R12 busy low with done", busy_o, 0);
      check(nw == 6, (extra > 0) ? "R11 write count with extra start" : "R1 write count", nw, 6);
      check(!bad_oe, "R9 output enable high", bad_oe, 0);
      check(!bad_wp, "R6 wp steady", bad_wp, 0);
      check(!bad_unused, "R8 unused strobe low", bad_unused, 0);
      check(!bad_stable, "R10 stable during strobe", bad_stable, 0);
      @(negedge clk);
      check(done_o == 1'b0, "R12 done one clock", done_o, 0);
      for (int k = 0; k < 20; k++) begin
         if (busy_o || !flash_we_n_o || !flash_ce_n_o) begin
            check(1'b0, (extra > 0) ? "R11 no restart" : "R8 idle strobes", busy_o, 0);
            break;
         end
         @(negedge clk);
      end
      check(flash_we_n_o && flash_ce_n_o, "R8 idle strobes high", {flash_we_n_o, flash_ce_n_o}, 3);
      check(wp_n_o == wpl, "R6 wp kept after done", wp_n_o, wpl);
   endtask

   task automatic test_reset();
      check(flash_we_n_o && flash_ce_n_o && flash_oe_n_o, "R8 reset strobes",
            {flash_we_n_o, flash_ce_n_o, flash_oe_n_o}, 7);
      check(busy_o == 1'b0 && done_o == 1'b0, "R12 reset busy/done", {busy_o, done_o}, 0);
   endtask

   task automatic test_block_we();
      run_erase(1'b0, 1'b0, 1'b1, 21'h1A_B000, 0);
   endtask

   task automatic test_sector_ce();
      run_erase(1'b1, 1'b1, 1'b0, 21'h0_3F00, 0);
   endtask

   task automatic test_start_while_busy();
      run_erase(1'b0, 1'b1, 1'b1, 21'h15_5000, 150);
   endtask

   task automatic test_sector_we_topaddr();
      run_erase(1'b1, 1'b0, 1'b1, 21'h1F_FFFF, 0);
   endtask

   initial begin
      #(200_000 * 10);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_block_we();
      test_sector_ce();
      test_start_while_busy();
      test_sector_we_topaddr();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule